// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block buffers 36-bit words between two unrelated clock domains. A producer pushes words on the write port under a write enable, and a consumer takes them from the read port under a read enable. Each port acts only on the rising edge of its own clock. The two clocks may run at unrelated rates or may be the same net.

The write and read pointers carry one extra wrap bit. They are Gray-coded and pass through two-flop synchronizers before the other domain sees them. The full-side flags are therefore formed in the write domain and the empty-side flags in the read domain.

The output behaviour is chosen by a mode input that is sampled while the full reset is held:

- **Standard mode.** Every word, including the first, needs a read request. The two status pins report empty and full.
- **Fall-through mode.** An output register picks up the head word without a read request. The same pins then report that output data is valid and that the FIFO can accept input.

Almost-empty and almost-full thresholds come from an external configuration source and are captured together with the mode. A partial reset flushes the contents but keeps the captured mode and thresholds.

Top module: `xfifo_fwft`

## Requirements
- R1: While full reset is held and after it is released, with nothing written, the flags have fixed values. In standard mode (`mode_in`=0 at reset): `ef_or`=1, `ff_ir`=0, `ae`=1, `af`=0 and `rd_data`=0. In fall-through mode (`mode_in`=1): `ef_or`=0 and `ff_ir`=1.
- R2: In standard mode, words leave in the order they were written. Each accepted read loads the next word onto `rd_data` at that read-clock edge. `rd_data` does not change without a read, even when a word is waiting.
- R3: In fall-through mode, `ef_or`=1 means `rd_data` holds a valid head word. The first word written to an empty FIFO reaches `rd_data` with no read. Each later word appears only after a read consumes the current head. `ef_or` falls when a read consumes the last word.
- R4: In standard mode `ff_ir` rises after DEPTH stored words. In fall-through mode `ff_ir`=1 while any memory location is free; with the output register that gives DEPTH+1 words in total.
- R5: A write while the FIFO is full (or not input-ready) is dropped. It moves no pointer and never appears at the output.
- R6: A read while the FIFO is empty (or not output-ready) moves no pointer and leaves `rd_data` unchanged.
- R7: `ae` is 1 when the read-side word count is at or below the captured empty offset. In fall-through mode that count includes the word held in the output register.
- R8: `af` is 1 when the free memory space seen by the write side is at or below the captured full offset.
- R9: A partial reset (`prst_n`=0) empties the FIFO and returns both pointers to the first location. The mode and both offsets keep the values captured at the last full reset; `mode_in` and the offset inputs are ignored during a partial reset.
- R10: A full reset (`rst_n`=0) empties the FIFO and captures new values of `mode_in`, `ae_ofs` and `af_ofs`.
- R11: With both ports on one clock, a write and a read on the same edge both complete. Each pointer's Gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low; captures mode and offsets |
| prst_n | input | 1 | Partial reset, active low; flushes data only |
| mode_in | input | 1 | 1 selects fall-through mode, 0 standard mode (sampled in full reset) |
| ae_ofs | input | $clog2(DEPTH)+1 | Almost-empty offset (sampled in full reset) |
| af_ofs | input | $clog2(DEPTH)+1 | Almost-full offset (sampled in full reset) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data / head word |
| ef_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| ae | output | 1 | Almost-empty |
| af | output | 1 | Almost-full |

## Verification
The hardest case to reach is the fall-through capacity of DEPTH+1 words. It only appears once the first word has left memory for the output register, and that move waits for the write pointer to cross into the read domain. The stimulus writes one word, lets both synchronizers settle, and then fills the memory to the brim.

A same-edge write and read is just as awkward, because the two clocks normally drift apart. The bench switches the read clock onto the write clock during a full reset so that both requests land on one edge.

The partial-reset test changes the mode and offset inputs while the partial reset is held. It then checks the flag meanings and the almost-empty threshold afterwards, so a wrongly recaptured configuration shows at the pins.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic {
    MODE_STD = 1'b0,
    MODE_FT  = 1'b1
  } fifo_mode_e;

endpackage

// File: rtl/xfifo_rst_sync.sv
// Asynchronous assert, synchronous release of a reset into one clock domain.
module xfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/xfifo_sync2.sv
// Two-flop synchronizer for a Gray-coded pointer.
module xfifo_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/xfifo_mem.sv
// Storage array: written on the write clock, read asynchronously by address.
module xfifo_mem #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] store [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
// Write-side pointer, full / input-ready flag and almost-full flag.
module xfifo_wr_ctl #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_rst_n,
  input  logic                     mode_in,
  input  logic [$clog2(DEPTH):0]   af_ofs_in,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH):0]   rgray_s,
  output logic                     push,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH):0]   wgray,
  output logic [$clog2(DEPTH):0]   wptr,
  output logic [$clog2(DEPTH):0]   wcount,
  output logic                     full,
  output logic                     ff_ir,
  output logic                     af
);
  import xfifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Gray value of a pointer that sits exactly one lap ahead of g.
  function automatic logic [PW-1:0] lap_ahead(input logic [PW-1:0] g);
    return {~g[PW-1:PW-2], g[PW-3:0]};
  endfunction

  fifo_mode_e    mode_q;
  logic [PW-1:0] af_ofs_q;
  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, rbin_s, wfree;

  // Configuration is captured only while the full reset is held.
  always_ff @(posedge clk) begin
    if (!cfg_rst_n) begin
      mode_q   <= fifo_mode_e'(mode_in);
      af_ofs_q <= af_ofs_in;
    end
  end

  assign full     = (wgray_q == lap_ahead(rgray_s));
  assign push     = wr_en & ~full;
  assign wptr_nxt = wptr_q + PW'(push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= bin_to_gray(wptr_nxt);
    end
  end

  assign rbin_s = gray_to_bin(rgray_s);
  assign wcount = wptr_q - rbin_s;
  assign wfree  = CAP - wcount;

  assign af    = (wfree <= af_ofs_q);
  assign ff_ir = (mode_q == MODE_FT) ? ~full : full;
  assign waddr = wptr_q[AW-1:0];
  assign wgray = wgray_q;
  assign wptr  = wptr_q;
endmodule

// File: rtl/xfifo_rd_ctl.sv
// Read-side pointer, output register, empty / output-ready and almost-empty.
module xfifo_rd_ctl #(
  parameter int DEPTH = 256,
  parameter int DW    = 36
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_rst_n,
  input  logic                     mode_in,
  input  logic [$clog2(DEPTH):0]   ae_ofs_in,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH):0]   wgray_s,
  input  logic [DW-1:0]            mem_rdata,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic [$clog2(DEPTH):0]   rgray,
  output logic [$clog2(DEPTH):0]   rptr,
  output logic                     mem_empty,
  output logic                     mode_ft,
  output logic                     out_valid,
  output logic [DW-1:0]            rd_data,
  output logic                     ef_or,
  output logic                     ae
);
  import xfifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words the consumer can still reach: memory words plus the held head.
  function automatic logic [PW-1:0] words_held(input logic [PW-1:0] wbin,
                                               input logic [PW-1:0] rbin,
                                               input logic          head);
    return wbin - rbin + PW'(head);
  endfunction

  fifo_mode_e    mode_q;
  logic [PW-1:0] ae_ofs_q;
  logic [PW-1:0] rptr_q, rptr_nxt, rgray_q, wbin_s, rcount;
  logic [DW-1:0] data_q;
  logic          valid_q;
  logic          pop_std, load_ft, fetch;

  always_ff @(posedge clk) begin
    if (!cfg_rst_n) begin
      mode_q   <= fifo_mode_e'(mode_in);
      ae_ofs_q <= ae_ofs_in;
    end
  end

  assign mode_ft   = (mode_q == MODE_FT);
  assign mem_empty = (rgray_q == wgray_s);
  assign pop_std   = ~mode_ft & rd_en & ~mem_empty;
  assign load_ft   = mode_ft & ~mem_empty & (~valid_q | rd_en);
  assign fetch     = pop_std | load_ft;
  assign rptr_nxt  = rptr_q + PW'(fetch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_q <= bin_to_gray(rptr_nxt);
      if (fetch) data_q <= mem_rdata;
      if (load_ft)                 valid_q <= 1'b1;
      else if (mode_ft && rd_en)   valid_q <= 1'b0;
    end
  end

  assign wbin_s = gray_to_bin(wgray_s);
  assign rcount = words_held(wbin_s, rptr_q, mode_ft & valid_q);

  assign ae        = (rcount <= ae_ofs_q);
  assign ef_or     = mode_ft ? valid_q : mem_empty;
  assign rd_data   = data_q;
  assign out_valid = valid_q;
  assign raddr     = rptr_q[AW-1:0];
  assign rgray     = rgray_q;
  assign rptr      = rptr_q;
endmodule

// File: rtl/xfifo_fwft.sv
module xfifo_fwft #(
  parameter int DEPTH = 256,
  parameter int DW    = 36
) (
  input  logic                   wr_clk,
  input  logic                   rd_clk,
  input  logic                   rst_n,
  input  logic                   prst_n,
  input  logic                   mode_in,
  input  logic [$clog2(DEPTH):0] ae_ofs,
  input  logic [$clog2(DEPTH):0] af_ofs,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  output logic                   ef_or,
  output logic                   ff_ir,
  output logic                   ae,
  output logic                   af
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events, observed by the bound checker.
  logic          any_rst_n;
  logic          w_rst_n, w_cfg_rst_n, r_rst_n, r_cfg_rst_n;
  logic          w_push, w_full;
  logic [AW-1:0] w_addr, r_addr;
  logic [PW-1:0] w_gray, w_ptr, w_count, r_gray, r_ptr;
  logic [PW-1:0] w_gray_at_r, r_gray_at_w;
  logic          r_mem_empty, r_mode_ft, r_out_valid;
  logic [DW-1:0] mem_q;

  assign any_rst_n = rst_n & prst_n;

  xfifo_rst_sync u_wrst  (.clk(wr_clk), .arst_n(any_rst_n), .srst_n(w_rst_n));
  xfifo_rst_sync u_wcfg  (.clk(wr_clk), .arst_n(rst_n),     .srst_n(w_cfg_rst_n));
  xfifo_rst_sync u_rrst  (.clk(rd_clk), .arst_n(any_rst_n), .srst_n(r_rst_n));
  xfifo_rst_sync u_rcfg  (.clk(rd_clk), .arst_n(rst_n),     .srst_n(r_cfg_rst_n));

  xfifo_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(w_rst_n), .d(r_gray), .q(r_gray_at_w));
  xfifo_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(r_rst_n), .d(w_gray), .q(w_gray_at_r));

  xfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(w_push), .waddr(w_addr), .wdata(wr_data),
    .raddr(r_addr), .rdata(mem_q)
  );

  xfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst_n(w_rst_n), .cfg_rst_n(w_cfg_rst_n),
    .mode_in(mode_in), .af_ofs_in(af_ofs), .wr_en(wr_en),
    .rgray_s(r_gray_at_w), .push(w_push), .waddr(w_addr), .wgray(w_gray),
    .wptr(w_ptr), .wcount(w_count), .full(w_full), .ff_ir(ff_ir), .af(af)
  );

  xfifo_rd_ctl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(r_rst_n), .cfg_rst_n(r_cfg_rst_n),
    .mode_in(mode_in), .ae_ofs_in(ae_ofs), .rd_en(rd_en),
    .wgray_s(w_gray_at_r), .mem_rdata(mem_q), .raddr(r_addr),
    .rgray(r_gray), .rptr(r_ptr), .mem_empty(r_mem_empty),
    .mode_ft(r_mode_ft), .out_valid(r_out_valid), .rd_data(rd_data),
    .ef_or(ef_or), .ae(ae)
  );
endmodule

// File: rtl/xfifo_fwft_chk.sv
module xfifo_fwft_chk #(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  parameter int PW    = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          w_full,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] w_count,
  input logic [PW-1:0] r_ptr,
  input logic [PW-1:0] r_gray,
  input logic          r_mem_empty,
  input logic          r_mode_ft,
  input logic          r_out_valid,
  input logic          rd_en,
  input logic [DW-1:0] rd_data
);
  assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    w_full |=> (w_ptr == $past(w_ptr)));

  assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    r_mem_empty |=> (r_ptr == $past(r_ptr)));

  assert_fill_bound_R4: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    w_count <= PW'(DEPTH));

  assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    $countones(r_gray ^ $past(r_gray)) <= 1);

  assert_last_word_drops_ready_R3: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_mode_ft && r_out_valid && rd_en && r_mem_empty) |=> !r_out_valid);

  assert_head_holds_R3: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_mode_ft && r_out_valid && !rd_en) |=> (r_out_valid && $stable(rd_data)));
endmodule

bind xfifo_fwft xfifo_fwft_chk #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .w_full(w_full), .w_ptr(w_ptr), .w_gray(w_gray), .w_count(w_count),
  .r_ptr(r_ptr), .r_gray(r_gray), .r_mem_empty(r_mem_empty),
  .r_mode_ft(r_mode_ft), .r_out_valid(r_out_valid), .rd_en(rd_en),
  .rd_data(rd_data)
);

// File: tb/test_xfifo_fwft.sv
`timescale 1ns/100ps
module test_xfifo_fwft;
  localparam int DEPTH = 16;
  localparam int DW    = 36;
  localparam int OW    = $clog2(DEPTH) + 1;

  logic wclk = 1'b0, rclk_free = 1'b0, share = 1'b0;
  wire  rclk = share ? wclk : rclk_free;
  always #2 wclk = ~wclk;
  always #3 rclk_free = ~rclk_free;

  logic          rst_n = 1'b0, prst_n = 1'b1, mode_in = 1'b0;
  logic [OW-1:0] ae_ofs = '0, af_ofs = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          ef_or, ff_ir, ae, af;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  xfifo_fwft #(.DEPTH(DEPTH), .DW(DW)) i_xfifo_fwft (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .prst_n(prst_n),
    .mode_in(mode_in), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ef_or(ef_or), .ff_ir(ff_ir), .ae(ae), .af(af)
  );

  // op bit 36: 1 = push value, 0 = pop and expect value (standard mode)
  localparam logic [36:0] VEC [0:9] = '{
    {1'b1, 36'h0_1234_5678}, {1'b1, 36'hF_0000_0001}, {1'b0, 36'h0_1234_5678},
    {1'b1, 36'hA_5A5A_5A5A}, {1'b0, 36'hF_0000_0001}, {1'b0, 36'hA_5A5A_5A5A},
    {1'b1, 36'h0_0000_0000}, {1'b1, 36'hF_FFFF_FFFF}, {1'b0, 36'h0_0000_0000},
    {1'b0, 36'hF_FFFF_FFFF}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
  endtask

  task automatic full_reset(input logic mode, input logic [OW-1:0] aeo,
                            input logic [OW-1:0] afo, input logic shr);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    mode_in = mode; ae_ofs = aeo; af_ofs = afo;
    #1 share = shr;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk_free);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: standard-mode reset state
    full_reset(1'b0, OW'(2), OW'(3), 1'b0);
    check("R1", "ef_or", ef_or, 1); check("R1", "ff_ir", ff_ir, 0);
    check("R1", "ae", ae, 1);       check("R1", "af", af, 0);
    check("R1", "rd_data", rd_data, 0);

    // R2: vector table, order preserved in standard mode
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][36]) push(VEC[i][35:0]);
      else begin
        pop();
        check("R2", "vector pop", rd_data, VEC[i][35:0]);
      end
      settle();
    end

    // R2: a waiting word does not appear without a read
    push(36'h1_1111_1111); settle();
    check("R2", "no read no data", rd_data, 36'hF_FFFF_FFFF);
    pop(); check("R2", "read fetches", rd_data, 36'h1_1111_1111);
    settle();

    // R6: read while empty is ignored
    pop(); settle();
    check("R6", "rd_data held", rd_data, 36'h1_1111_1111);
    check("R6", "still empty", ef_or, 1);
    push(36'h2_2222_2222); settle();
    pop(); check("R6", "pointer unmoved", rd_data, 36'h2_2222_2222);

    // R4 R5 R7 R8: fill, overflow, thresholds (ae_ofs=2, af_ofs=3)
    full_reset(1'b0, OW'(2), OW'(3), 1'b0);
    for (int i = 0; i < 12; i++) push(DW'(i + 100));
    settle();
    check("R8", "free 4 af", af, 0);
    push(DW'(112)); settle();
    check("R8", "free 3 af", af, 1);
    for (int i = 13; i < DEPTH; i++) push(DW'(i + 100));
    settle();
    check("R4", "full after DEPTH", ff_ir, 1);
    push(36'hB_BADB_ADBA); settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      check("R5", "drain order", rd_data, DW'(i + 100));
      if (i == DEPTH - 4) begin settle(); check("R7", "count 3 ae", ae, 0); end
      if (i == DEPTH - 3) begin settle(); check("R7", "count 2 ae", ae, 1); end
    end
    settle();
    check("R5", "empty after DEPTH", ef_or, 1);
    check("R4", "not full", ff_ir, 0);

    // R10 R1: full reset recaptures fall-through mode
    full_reset(1'b1, OW'(2), OW'(3), 1'b0);
    check("R10", "ready low", ef_or, 0); check("R10", "input ready", ff_ir, 1);
    check("R1", "ae", ae, 1);

    // R3: fall-through
    push(36'h3_0000_0001); settle();
    check("R3", "ready w/o read", ef_or, 1);
    check("R3", "head w/o read", rd_data, 36'h3_0000_0001);
    push(36'h3_0000_0002); settle();
    check("R3", "head held", rd_data, 36'h3_0000_0001);
    pop(); check("R3", "next head", rd_data, 36'h3_0000_0002);
    check("R3", "still ready", ef_or, 1);
    pop(); check("R3", "last consumed", ef_or, 0);
    settle();

    // R7: almost-empty counts the held head in fall-through mode
    push(36'h4_0000_0001); push(36'h4_0000_0002); settle();
    check("R7", "2 words ae", ae, 1);
    push(36'h4_0000_0003); settle();
    check("R7", "3 words ae", ae, 0);

    // R4 R5: fall-through capacity DEPTH+1
    full_reset(1'b1, OW'(2), OW'(3), 1'b0);
    push(DW'(500)); settle();
    for (int i = 1; i <= DEPTH; i++) push(DW'(500 + i));
    settle();
    check("R4", "not input ready", ff_ir, 0);
    push(36'hD_EADD_EADD); settle();
    for (int i = 0; i <= DEPTH; i++) begin
      check("R5", "ft drain", rd_data, DW'(500 + i));
      pop();
    end
    settle();
    check("R5", "ft empty", ef_or, 0);

    // R9: partial reset flushes, keeps mode and offsets
    push(36'h5_0000_0001); push(36'h5_0000_0002); settle();
    prst_n = 1'b0; mode_in = 1'b0; ae_ofs = OW'(9); af_ofs = OW'(0);
    repeat (4) @(negedge wclk); repeat (4) @(negedge rclk);
    prst_n = 1'b1; settle();
    check("R9", "flushed, ft meaning", ef_or, 0);
    check("R9", "input ready kept", ff_ir, 1);
    push(36'h5_0000_0003); push(36'h5_0000_0004); push(36'h5_0000_0005); settle();
    check("R9", "ae offset kept", ae, 0);
    check("R9", "first after flush", rd_data, 36'h5_0000_0003);

    // R11: shared clock, same-edge write and read
    full_reset(1'b0, OW'(2), OW'(3), 1'b1);
    push(36'h6_0000_0001); push(36'h6_0000_0002); settle();
    @(negedge wclk); wr_en = 1'b1; wr_data = 36'h6_0000_0003; rd_en = 1'b1;
    @(negedge wclk); wr_en = 1'b0; rd_en = 1'b0;
    check("R11", "same-edge read", rd_data, 36'h6_0000_0001);
    settle();
    pop(); check("R11", "second", rd_data, 36'h6_0000_0002);
    pop(); check("R11", "same-edge write", rd_data, 36'h6_0000_0003);
    settle();
    check("R11", "empty after", ef_or, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule